// File: doc/BRIEF.md
# Trace Decode Signature Generator

This block sits beside the decode stage of a processor and condenses the stream of decoded control words into one compact signature per trace. Every cycle it may accept one decoded instruction: its 64-bit control word, its program counter and a flag that marks it as a branch. It keeps a running XOR of the control words of the current trace and remembers the program counter of the trace's first instruction.

A trace closes on the first branch or on its sixteenth instruction, whichever comes first. The closing instruction belongs to the trace that it closes. When a trace closes, the block presents a record for one cycle. The record holds the start PC, the signature and the number of instructions in the trace. A downstream checker can compare that signature against an earlier one that was stored for the same start PC.

A flush input throws away any partial trace. Decode words that arrive on later cycles start a fresh trace.

Top module: `trace_sig_gen`

## Requirements
- R1: After a synchronous reset, `rec_valid` is 0 and `rec_pc`, `rec_sig` and `rec_len` are all zero.
- R2: `rec_sig` equals the bitwise XOR of the decode words of every instruction in the trace.
- R3: An accepted instruction with `dec_branch`=1 is folded into the current trace, and that trace then closes. The next accepted instruction starts a new trace.
- R4: A trace that has no branch closes on its MAX_LEN-th (16th) accepted instruction, and the following instruction starts a new trace.
- R5: `rec_pc` is the `dec_pc` of the first instruction accepted into the trace.
- R6: `rec_len` is the number of instructions in the trace, from 1 to MAX_LEN.
- R7: `rec_valid` is high for exactly one cycle per closed trace, in the cycle right after the clock edge that accepted the closing instruction.
- R8: When `flush`=1, the partial trace and any instruction offered in that same cycle are dropped. No record is produced for them, and the next accepted instruction starts a new trace whose signature begins from zero.
- R9: A trace of a single instruction yields that instruction's decode word unchanged as its signature.
- R10: Cycles with `dec_valid`=0 and `flush`=0 leave the trace untouched and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is offered this cycle |
| dec_pc | input | PC_W (32) | Program counter of the offered instruction |
| dec_word | input | WORD_W (64) | Decoded control word |
| dec_branch | input | 1 | The offered instruction is a branch |
| flush | input | 1 | Discard the partial trace |
| rec_valid | output | 1 | Trace record strobe, one cycle |
| rec_pc | output | PC_W (32) | Start PC of the closed trace |
| rec_sig | output | WORD_W (64) | XOR signature of the closed trace |
| rec_len | output | CNT_W (5) | Instruction count of the closed trace |

## Verification
Each record is due exactly one clock edge after the edge that accepts its closing instruction. On every other cycle, including the cycle after a flush or an idle input, `rec_valid` must be low. The bench drives each input set at a falling edge and samples the outputs at the next falling edge. Every check therefore looks at the state produced by exactly one rising edge. Checks run on every cycle, so a record that comes early, late or twice is caught. The sweeps cover every trace length from 1 to 16 ending on a branch, long branch-free runs that split at the cap, idle gaps, back-to-back branches, and flushes at several positions, including on the would-be closing instruction.

// File: rtl/trace_sig_pkg.sv
package trace_sig_pkg;

    localparam int unsigned DEF_PC_W    = 32;
    localparam int unsigned DEF_WORD_W  = 64;
    localparam int unsigned DEF_MAX_LEN = 16;

    // What the current cycle does to the open trace
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_EXTEND = 2'd1,
        EV_CLOSE  = 2'd2,
        EV_DROP   = 2'd3
    } trace_ev_e;

    function automatic int unsigned cnt_width(input int unsigned max_len);
        return $clog2(max_len + 1);
    endfunction

endpackage

// File: rtl/trace_len_ctrl.sv
module trace_len_ctrl
    import trace_sig_pkg::*;
#(
    parameter int unsigned MAX_LEN = DEF_MAX_LEN,
    parameter int unsigned CNT_W   = cnt_width(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             is_branch,
    input  logic             drop,
    output trace_ev_e        ev,
    output logic [CNT_W-1:0] len_now,
    output logic             first
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_LEN - 1);

    logic [CNT_W-1:0] held;

    always_comb begin
        if (drop)
            ev = EV_DROP;
        else if (take && (is_branch || held == LAST_IDX))
            ev = EV_CLOSE;
        else if (take)
            ev = EV_EXTEND;
        else
            ev = EV_NONE;
    end

    assign len_now = held + CNT_W'(1);
    assign first   = (held == '0);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else begin
            case (ev)
                EV_DROP, EV_CLOSE: held <= '0;
                EV_EXTEND:         held <= held + CNT_W'(1);
                default:           held <= held;
            endcase
        end
    end

    // R4: an open trace never holds MAX_LEN instructions
    p_held_bound_r4: assert property (@(posedge clk) disable iff (rst)
        held <= LAST_IDX);

    // R8: a drop empties the trace
    p_drop_empties_r8: assert property (@(posedge clk) disable iff (rst)
        drop |=> held == '0);

endmodule

// File: rtl/sig_accum.sv
module sig_accum
    import trace_sig_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  trace_ev_e         ev,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] fold
);
    logic [WORD_W-1:0] acc;

    assign fold = acc ^ word;

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else begin
            case (ev)
                EV_DROP, EV_CLOSE: acc <= '0;
                EV_EXTEND:         acc <= fold;
                default:           acc <= acc;
            endcase
        end
    end

    // R8 / R9: every new trace starts from a zero accumulator
    p_acc_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_DROP || ev == EV_CLOSE) |=> acc == '0);

    // R10: idle cycles hold the accumulator
    p_acc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ev == EV_NONE |=> $stable(acc));

endmodule

// File: rtl/trace_sig_gen.sv
module trace_sig_gen
    import trace_sig_pkg::*;
#(
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned MAX_LEN = DEF_MAX_LEN,
    parameter int unsigned CNT_W   = cnt_width(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [PC_W-1:0]   dec_pc,
    input  logic [WORD_W-1:0] dec_word,
    input  logic              dec_branch,
    input  logic              flush,
    output logic              rec_valid,
    output logic [PC_W-1:0]   rec_pc,
    output logic [WORD_W-1:0] rec_sig,
    output logic [CNT_W-1:0]  rec_len
);
    trace_ev_e         ev;
    logic [CNT_W-1:0]  len_now;
    logic              first;
    logic [WORD_W-1:0] fold;
    logic [PC_W-1:0]   start_pc;

    trace_len_ctrl #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_len (
        .clk       (clk),
        .rst       (rst),
        .take      (dec_valid),
        .is_branch (dec_branch),
        .drop      (flush),
        .ev        (ev),
        .len_now   (len_now),
        .first     (first)
    );

    sig_accum #(.WORD_W(WORD_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .word (dec_word),
        .fold (fold)
    );

    always_ff @(posedge clk) begin
        if (rst)
            start_pc <= '0;
        else if (ev == EV_EXTEND && first)
            start_pc <= dec_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_pc    <= '0;
            rec_sig   <= '0;
            rec_len   <= '0;
        end else if (ev == EV_CLOSE) begin
            rec_valid <= 1'b1;
            rec_pc    <= first ? dec_pc : start_pc;
            rec_sig   <= fold;
            rec_len   <= len_now;
        end else begin
            rec_valid <= 1'b0;
        end
    end

    // R3: a branch accepted without flush closes its trace on the next edge
    p_branch_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_branch && !flush) |=> rec_valid);

    // R6: record length lies in 1..MAX_LEN
    p_len_range_r6: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_len != '0 && rec_len <= CNT_W'(MAX_LEN)));

    // R8: a flush cycle yields no record
    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rec_valid);

    // R9: a one-instruction trace carries that word and PC
    p_single_word_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !flush && $past(rec_valid == 1'b0 || rec_valid == 1'b1))
        |=> (rec_valid && rec_len == CNT_W'(1)) -> (rec_sig == $past(dec_word) && rec_pc == $past(dec_pc)));

    // R10: an idle cycle yields no record
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid && !flush) |=> !rec_valid);

endmodule

// File: tb/trace_sig_gen_test.sv
module trace_sig_gen_test;
    localparam int PC_W = 32;
    localparam int WORD_W = 64;
    localparam int MAX_LEN = 16;
    localparam int CNT_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dec_valid = 1'b0;
    logic [PC_W-1:0]   dec_pc = '0;
    logic [WORD_W-1:0] dec_word = '0;
    logic              dec_branch = 1'b0;
    logic              flush = 1'b0;
    logic              rec_valid;
    logic [PC_W-1:0]   rec_pc;
    logic [WORD_W-1:0] rec_sig;
    logic [CNT_W-1:0]  rec_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the open trace
    logic [WORD_W-1:0] m_acc = '0;
    int                m_cnt = 0;
    logic [PC_W-1:0]   m_pc = '0;

    always #10 clk = ~clk;

    trace_sig_gen uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_pc(dec_pc),
        .dec_word(dec_word), .dec_branch(dec_branch), .flush(flush),
        .rec_valid(rec_valid), .rec_pc(rec_pc), .rec_sig(rec_sig), .rec_len(rec_len)
    );

    function automatic logic [WORD_W-1:0] mk(input int t, input int i);
        logic [31:0] hi, lo;
        hi = 32'(t) * 32'h01000193 + 32'(i) * 32'h9E3779B9;
        lo = (32'(t) + 32'd1) * (32'(i) + 32'd7) * 32'h85EBCA6B;
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check one rising edge later
    task automatic step(input bit v, input logic [PC_W-1:0] pc, input logic [WORD_W-1:0] w,
                        input bit br, input bit fl, input string tag);
        bit               e_valid;
        logic [PC_W-1:0]  e_pc;
        logic [WORD_W-1:0] e_sig;
        int               e_len;
        e_valid = 0; e_pc = '0; e_sig = '0; e_len = 0;
        dec_valid = v; dec_pc = pc; dec_word = w; dec_branch = br; flush = fl;
        if (fl) begin
            m_acc = '0; m_cnt = 0;
        end else if (v) begin
            if (m_cnt == 0) m_pc = pc;
            m_acc = m_acc ^ w;
            m_cnt++;
            if (br || m_cnt == MAX_LEN) begin
                e_valid = 1; e_pc = m_pc; e_sig = m_acc; e_len = m_cnt;
                m_acc = '0; m_cnt = 0;
            end
        end
        @(negedge clk);
        chk(rec_valid == e_valid, tag, "R7 rec_valid", 64'(rec_valid), 64'(e_valid));
        if (e_valid && rec_valid) begin
            chk(rec_sig == e_sig, tag, "R2 rec_sig", rec_sig, e_sig);
            chk(rec_pc == e_pc, tag, "R5 rec_pc", 64'(rec_pc), 64'(e_pc));
            chk(int'(rec_len) == e_len, tag, "R6 rec_len", 64'(rec_len), 64'(e_len));
        end
        dec_valid = 0; dec_branch = 0; flush = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int pc;
        pc = 32'h1000;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(rec_valid == 1'b0, "R1", "rec_valid", 64'(rec_valid), 64'd0);
        chk(rec_sig == '0, "R1", "rec_sig", rec_sig, 64'd0);
        chk(rec_pc == '0 && rec_len == '0, "R1", "rec_pc/len", 64'(rec_pc), 64'd0);

        // R3 / R9: every length 1..16 ending on a branch
        for (int len = 1; len <= MAX_LEN; len++)
            for (int i = 0; i < len; i++) begin
                step(1, 32'(pc), mk(len, i), i == len - 1, 0, len == 1 ? "R9" : "R3");
                pc += 4;
            end

        // R4: long branch-free run splits at the cap
        for (int i = 0; i < 40; i++) begin
            step(1, 32'(pc), mk(100, i), i == 39, 0, "R4");
            pc += 4;
        end

        // R10: idle gaps every third cycle inside traces
        for (int t = 0; t < 6; t++)
            for (int i = 0; i < 9; i++) begin
                if (i % 3 == 2) step(0, 32'hDEAD0000, ~mk(7, i), 1, 0, "R10");
                else begin
                    step(1, 32'(pc), mk(200 + t, i), i == 7 && t[0], 0, "R10");
                    pc += 4;
                end
            end
        // close whatever remains
        step(1, 32'(pc), mk(300, 0), 1, 0, "R3");
        pc += 4;

        // R3 / R9: back-to-back branches
        for (int i = 0; i < 8; i++) begin
            step(1, 32'(pc), mk(400, i), 1, 0, "R9");
            pc += 4;
        end

        // R8: flush at every position, with and without an instruction in the flush cycle
        for (int pos = 0; pos < MAX_LEN; pos++) begin
            for (int i = 0; i < pos; i++) begin
                step(1, 32'(pc), mk(500 + pos, i), 0, 0, "R8");
                pc += 4;
            end
            step(pos[0], 32'(pc), mk(600, pos), pos == 3, 1, "R8");
            pc += 4;
            for (int i = 0; i < 3; i++) begin
                step(1, 32'(pc), mk(700 + pos, i), i == 2, 0, "R8");
                pc += 4;
            end
        end

        // R8: flush exactly on the would-be closing 16th instruction
        for (int i = 0; i < MAX_LEN - 1; i++) begin
            step(1, 32'(pc), mk(800, i), 0, 0, "R8");
            pc += 4;
        end
        step(1, 32'(pc), mk(800, 15), 0, 1, "R8");
        step(1, 32'(pc + 4), mk(801, 0), 1, 0, "R9");

        repeat (2) step(0, '0, '0, 0, 0, "R10");
        finish_run();
    end
endmodule